// File: doc/BRIEF.md
# Parallel Camera Sync Capture Front-End

This block receives pixels from an image sensor that marks lines and frames with two dedicated sync wires, one horizontal and one vertical, rather than codes embedded in the data stream. The sensor's pixel clock, the two sync lines and the pixel bus are registered in the system clock domain. The selected pixel-clock edge is detected there, so every sensor sample becomes a one-cycle sample strobe. While a frame is open and its line is active, pixels are packed into 32-bit words. Each finished word is presented on a single-cycle write strobe to a downstream FIFO.

Four one-cycle event outputs mark frame start, frame end, line start and line end. The enable is frame-aware. Dropping it either ends capture at once or lets the current frame finish. Capture can also be held back until the vertical sync actually becomes active, so that the first captured frame is a whole one.

The controller has three states:
- `ST_OFF`: idle.
- `ST_ARMED`: enabled and waiting for a frame.
- `ST_ACTIVE`: capturing.

Its transitions are:
- OFF→ARMED on enable.
- ARMED→OFF when enable drops.
- ARMED→ACTIVE on the start condition.
- ACTIVE→ARMED at frame end while still enabled.
- ACTIVE→OFF at frame end while disabled.
- ACTIVE→OFF at once when enable is low with frame-bounded stop off.
- Any state→OFF on an accepted core reset.

Top module: `cam_par_capture`

## Requirements
- R1: While reset is held, `fifo_wr`, `fifo_data` and all four event outputs are 0.
- R2: With `clk_pol`=0 pixels are taken on the rising edge of `pclk`; with `clk_pol`=1 on the falling edge. Bus values present only around the other edge are never captured.
- R3: With `hs_pol`/`vs_pol` at 0 the matching sync is active high; at 1 it is active low. Captured words and events are otherwise identical.
- R4: With `width_mode`=000 (8-bit), pixel bits [7:0] are taken and four pixels fill one word. The first pixel of a group goes to bits [7:0], the second to [15:8], the third to [23:16] and the fourth to [31:24]. Higher bus bits are ignored.
- R5: With `width_mode`=001 (10-bit) or 010 (12-bit), bits [9:0] or [11:0] are taken and zero-extended to 16 bits. Two pixels fill one word, the first in bits [15:0] and the second in [31:16].
- R6: With `swap`=1, the lane order inside a word is reversed: the first pixel of a group goes to the highest lane.
- R7: When a line ends with an incomplete word, that word is written with its unfilled lanes at zero.
- R8: Any other `width_mode` code (011, 1xx) writes no words, while the sync events still occur.
- R9: Events are pulses of exactly one system-clock cycle.
  - Frame start fires on entry to capture.
  - Frame end fires when vertical sync goes inactive during capture.
  - Line start and line end fire on the active and inactive edges of horizontal sync inside a captured frame.
- R10: With `start_align`=0, capture starts at any sample taken while vertical sync is active. With `start_align`=1, it starts only on an inactive-to-active transition of vertical sync, so a frame already in progress at enable is skipped.
- R11: When `enable` falls with `frame_trig`=1, the current frame completes and no later frame is captured. With `frame_trig`=0, no further words or events are produced after that point.
- R12: `core_rst` returns the block to idle and discards any partial word, but only while `enable` is low. With `enable` high it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk | input | 1 | Sensor pixel clock, sampled as data |
| hsync | input | 1 | Horizontal sync from the sensor |
| vsync | input | 1 | Vertical sync from the sensor |
| pix_data | input | DATA_W | Sensor pixel bus |
| enable | input | 1 | Capture enable |
| frame_trig | input | 1 | 1: disabling waits for frame end; 0: disabling is immediate |
| start_align | input | 1 | 1: begin only on a vertical sync activation |
| hs_pol | input | 1 | Horizontal sync polarity, 1 = active low |
| vs_pol | input | 1 | Vertical sync polarity, 1 = active low |
| clk_pol | input | 1 | Sampling edge, 0 = rising, 1 = falling |
| width_mode | input | 3 | Pixel width code |
| swap | input | 1 | Reverse lane order within a word |
| core_rst | input | 1 | Return to idle (accepted only while disabled) |
| fifo_wr | output | 1 | One-cycle write strobe for a packed word |
| fifo_data | output | 32 | Packed word, valid with `fifo_wr` |
| frame_start | output | 1 | Frame start pulse |
| frame_end | output | 1 | Frame end pulse |
| line_start | output | 1 | Line start pulse |
| line_end | output | 1 | Line end pulse |

## Verification
The assertions take for granted that the pixel clock stays at each level for at least two system-clock cycles. Two sample strobes therefore never fall on adjacent cycles. The configuration inputs are assumed to change only while the block is disabled. The stimulus holds each pixel-clock level for three system cycles and changes the bus to a complemented value between the two edges. It reconfigures only after dropping the enable and pulsing the core reset.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } cap_state_e;

    localparam int WORD_W = 32;

    localparam logic [2:0] MODE_8  = 3'b000;
    localparam logic [2:0] MODE_10 = 3'b001;
    localparam logic [2:0] MODE_12 = 3'b010;

endpackage

// File: rtl/cam_cap_sampler.sv
module cam_cap_sampler #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pclk,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [DATA_W-1:0] pix_in,
    input  logic              hs_pol,
    input  logic              vs_pol,
    input  logic              clk_pol,
    output logic              tick,
    output logic              hs_act,
    output logic              vs_act,
    output logic              hs_last,
    output logic              vs_last,
    output logic [DATA_W-1:0] pix
);

    logic              pclk_s;
    logic              pclk_d;
    logic              hs_s;
    logic              vs_s;
    logic [DATA_W-1:0] pix_s;
    logic              tick_c;

    // input registers, syncs normalised to active-high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk_s <= 1'b0;
            pclk_d <= 1'b0;
            hs_s   <= 1'b0;
            vs_s   <= 1'b0;
            pix_s  <= '0;
        end else begin
            pclk_s <= pclk;
            pclk_d <= pclk_s;
            hs_s   <= hsync ^ hs_pol;
            vs_s   <= vsync ^ vs_pol;
            pix_s  <= pix_in;
        end
    end

    always_comb begin
        if (clk_pol) tick_c = pclk_d & ~pclk_s;
        else         tick_c = pclk_s & ~pclk_d;
    end

    // sample stage: current and previous sync levels per sensor sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick    <= 1'b0;
            hs_act  <= 1'b0;
            vs_act  <= 1'b0;
            hs_last <= 1'b0;
            vs_last <= 1'b0;
            pix     <= '0;
        end else if (clr) begin
            tick    <= 1'b0;
            hs_act  <= 1'b0;
            vs_act  <= 1'b0;
            hs_last <= 1'b0;
            vs_last <= 1'b0;
            pix     <= '0;
        end else begin
            tick <= tick_c;
            if (tick_c) begin
                hs_act  <= hs_s;
                vs_act  <= vs_s;
                hs_last <= hs_act;
                vs_last <= vs_act;
                pix     <= pix_s;
            end
        end
    end

endmodule

// File: rtl/cam_cap_ctrl.sv
module cam_cap_ctrl
    import cam_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic enable,
    input  logic frame_trig,
    input  logic start_align,
    input  logic mode_ok,
    input  logic tick,
    input  logic hs_act,
    input  logic vs_act,
    input  logic hs_last,
    input  logic vs_last,
    output logic take,
    output logic flush,
    output logic capturing,
    output logic frame_start,
    output logic frame_end,
    output logic line_start,
    output logic line_end
);

    cap_state_e state;
    cap_state_e state_nx;
    logic       in_line;
    logic       fs_c;
    logic       fe_c;
    logic       ls_c;
    logic       le_c;
    logic       stop_now;

    always_comb begin
        capturing = (state == ST_ACTIVE);
        stop_now  = !enable && !frame_trig;
        fs_c  = (state == ST_ARMED) && enable && tick && vs_act &&
                (!start_align || !vs_last);
        fe_c  = capturing && tick && !vs_act && vs_last;
        ls_c  = capturing && tick && vs_act && hs_act && !hs_last;
        le_c  = capturing && tick && vs_act && !hs_act && hs_last && in_line;
        take  = capturing && tick && vs_act && hs_act &&
                (in_line || !hs_last) && mode_ok;
        flush = le_c && mode_ok;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:    if (enable) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (!enable)   state_nx = ST_OFF;
                else if (fs_c) state_nx = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (stop_now)  state_nx = ST_OFF;
                else if (fe_c) state_nx = enable ? ST_ARMED : ST_OFF;
            end
            default:           state_nx = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_OFF;
        else if (clr) state <= ST_OFF;
        else          state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            line_start  <= 1'b0;
            line_end    <= 1'b0;
            in_line     <= 1'b0;
        end else if (clr) begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            line_start  <= 1'b0;
            line_end    <= 1'b0;
            in_line     <= 1'b0;
        end else begin
            frame_start <= fs_c;
            frame_end   <= fe_c;
            line_start  <= ls_c;
            line_end    <= le_c;
            if (state_nx != ST_ACTIVE) in_line <= 1'b0;
            else if (ls_c)             in_line <= 1'b1;
            else if (le_c)             in_line <= 1'b0;
        end
    end

endmodule

// File: rtl/cam_cap_packer.sv
module cam_cap_packer
    import cam_cap_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              drop,
    input  logic [2:0]        width_mode,
    input  logic              swap,
    input  logic              take,
    input  logic              flush,
    input  logic [DATA_W-1:0] pix,
    output logic              wr,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] acc;
    logic [1:0]        idx;
    logic              wide;
    logic [1:0]        last_idx;
    logic [1:0]        lane;
    logic [4:0]        shamt;
    logic [4:0]        pix_w;
    logic [WORD_W-1:0] pix_ext;
    logic [WORD_W-1:0] merged;

    always_comb begin
        wide     = (width_mode != MODE_8);
        last_idx = wide ? 2'd1 : 2'd3;
        case (width_mode)
            MODE_8:  pix_w = 5'd8;
            MODE_10: pix_w = 5'd10;
            default: pix_w = 5'd12;
        endcase
        pix_ext = WORD_W'(pix) & ((WORD_W'(1) << pix_w) - WORD_W'(1));
        lane    = swap ? (last_idx - idx) : idx;
        shamt   = wide ? {lane[0], 4'b0000} : {lane, 3'b000};
        merged  = acc | (pix_ext << shamt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            idx  <= '0;
            wr   <= 1'b0;
            word <= '0;
        end else if (clr_all) begin
            acc  <= '0;
            idx  <= '0;
            wr   <= 1'b0;
            word <= '0;
        end else begin
            wr <= 1'b0;
            if (drop) begin
                acc <= '0;
                idx <= '0;
            end else if (take) begin
                if (idx == last_idx) begin
                    word <= merged;
                    wr   <= 1'b1;
                    acc  <= '0;
                    idx  <= '0;
                end else begin
                    acc <= merged;
                    idx <= idx + 2'd1;
                end
            end else if (flush && (idx != 2'd0)) begin
                word <= acc;
                wr   <= 1'b1;
                acc  <= '0;
                idx  <= '0;
            end
        end
    end

endmodule

// File: rtl/cam_par_capture.sv
module cam_par_capture
    import cam_cap_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              enable,
    input  logic              frame_trig,
    input  logic              start_align,
    input  logic              hs_pol,
    input  logic              vs_pol,
    input  logic              clk_pol,
    input  logic [2:0]        width_mode,
    input  logic              swap,
    input  logic              core_rst,
    output logic              fifo_wr,
    output logic [31:0]       fifo_data,
    output logic              frame_start,
    output logic              frame_end,
    output logic              line_start,
    output logic              line_end
);

    logic              cr_eff;
    logic              mode_ok;
    logic              tick;
    logic              hs_act;
    logic              vs_act;
    logic              hs_last;
    logic              vs_last;
    logic [DATA_W-1:0] pix;
    logic              take;
    logic              flush;
    logic              capturing;

    assign cr_eff  = core_rst && !enable;
    assign mode_ok = (width_mode == MODE_8) || (width_mode == MODE_10) ||
                     (width_mode == MODE_12);

    cam_cap_sampler #(.DATA_W(DATA_W)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cr_eff),
        .pclk    (pclk),
        .hsync   (hsync),
        .vsync   (vsync),
        .pix_in  (pix_data),
        .hs_pol  (hs_pol),
        .vs_pol  (vs_pol),
        .clk_pol (clk_pol),
        .tick    (tick),
        .hs_act  (hs_act),
        .vs_act  (vs_act),
        .hs_last (hs_last),
        .vs_last (vs_last),
        .pix     (pix)
    );

    cam_cap_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (cr_eff),
        .enable      (enable),
        .frame_trig  (frame_trig),
        .start_align (start_align),
        .mode_ok     (mode_ok),
        .tick        (tick),
        .hs_act      (hs_act),
        .vs_act      (vs_act),
        .hs_last     (hs_last),
        .vs_last     (vs_last),
        .take        (take),
        .flush       (flush),
        .capturing   (capturing),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .line_start  (line_start),
        .line_end    (line_end)
    );

    cam_cap_packer #(.DATA_W(DATA_W)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (cr_eff),
        .drop       (!capturing),
        .width_mode (width_mode),
        .swap       (swap),
        .take       (take),
        .flush      (flush),
        .pix        (pix),
        .wr         (fifo_wr),
        .word       (fifo_data)
    );

endmodule

// File: rtl/cam_cap_checker.sv
module cam_cap_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       frame_trig,
    input logic       core_rst,
    input logic [2:0] width_mode,
    input logic       fifo_wr,
    input logic       frame_start,
    input logic       frame_end,
    input logic       line_start,
    input logic       line_end
);

    logic any_out;
    assign any_out = fifo_wr | frame_start | frame_end | line_start | line_end;

    // R9: single-cycle event pulses
    a_r9_fs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    a_r9_fe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);
    a_r9_ls_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);
    a_r9_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start, frame_end, line_start, line_end}));

    // R11: immediate stop leaves outputs quiet
    a_r11_immediate_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!enable && !frame_trig) && !enable && !frame_trig) |=> !any_out);

    // R12: an accepted core reset silences everything on the next cycle
    a_r12_core_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && !enable) |=> !any_out);

    // R8: unsupported width codes produce no writes
    a_r8_no_write_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !(width_mode == 3'b000 || width_mode == 3'b001 || width_mode == 3'b010)
        |=> !fifo_wr);

endmodule

bind cam_par_capture cam_cap_checker u_cam_cap_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .frame_trig  (frame_trig),
    .core_rst    (core_rst),
    .width_mode  (width_mode),
    .fifo_wr     (fifo_wr),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .line_start  (line_start),
    .line_end    (line_end)
);

// File: tb/test_cam_par_capture.sv
module test_cam_par_capture;

    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pclk = 1'b0;
    logic          hsync = 1'b0;
    logic          vsync = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic          enable = 1'b0;
    logic          frame_trig = 1'b1;
    logic          start_align = 1'b1;
    logic          hs_pol = 1'b0;
    logic          vs_pol = 1'b0;
    logic          clk_pol = 1'b0;
    logic [2:0]    width_mode = 3'b000;
    logic          swap = 1'b0;
    logic          core_rst = 1'b0;
    logic          fifo_wr;
    logic [31:0]   fifo_data;
    logic          frame_start;
    logic          frame_end;
    logic          line_start;
    logic          line_end;

    cam_par_capture #(.DATA_W(DW)) i_cam_par_capture (
        .clk(clk), .rst_n(rst_n), .pclk(pclk), .hsync(hsync), .vsync(vsync),
        .pix_data(pix_data), .enable(enable), .frame_trig(frame_trig),
        .start_align(start_align), .hs_pol(hs_pol), .vs_pol(vs_pol),
        .clk_pol(clk_pol), .width_mode(width_mode), .swap(swap),
        .core_rst(core_rst), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .frame_start(frame_start), .frame_end(frame_end),
        .line_start(line_start), .line_end(line_end)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];
    int fs_n = 0, fe_n = 0, ls_n = 0, le_n = 0;
    int q0, fs0, fe0, ls0, le0;
    int efs, efe, els, ele;

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr)     got_q.push_back(fifo_data);
            if (frame_start) fs_n++;
            if (frame_end)   fe_n++;
            if (line_start)  ls_n++;
            if (line_end)    le_n++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pval(int seed, int ln, int i);
        return DW'(seed * 37 + ln * 13 + i * 5 + 32'hA05);
    endfunction

    // one sensor sample: sampling edge first, bus complemented before the other edge
    task automatic pc(input logic h, input logic v, input logic [DW-1:0] d);
        @(negedge clk);
        hsync    = h ^ hs_pol;
        vsync    = v ^ vs_pol;
        pix_data = d;
        pclk     = clk_pol;
        repeat (2) @(negedge clk);
        pclk = ~clk_pol;
        repeat (3) @(negedge clk);
        pix_data = ~d;
        pclk     = clk_pol;
    endtask

    task automatic send_line(input int np, input int seed, input int ln);
        for (int i = 0; i < np; i++) pc(1'b1, 1'b1, pval(seed, ln, i));
        pc(1'b0, 1'b1, '0);
        pc(1'b0, 1'b1, '0);
    endtask

    task automatic frame_open();
        pc(1'b0, 1'b0, '0);
        pc(1'b0, 1'b1, '0);
        pc(1'b0, 1'b1, '0);
    endtask

    task automatic frame_close();
        pc(1'b0, 1'b0, '0);
        pc(1'b0, 1'b0, '0);
    endtask

    // expected words of one line, computed from R4..R7
    task automatic exp_line(input int mode, input int sw, input int np,
                            input int seed, input int ln);
        int w;
        int nl;
        int lw;
        logic [31:0] acc;
        w   = (mode == 0) ? 8 : ((mode == 1) ? 10 : 12);
        nl  = (mode == 0) ? 4 : 2;
        lw  = 32 / nl;
        acc = '0;
        for (int i = 0; i < np; i++) begin
            int k;
            int lane;
            k    = i % nl;
            lane = (sw != 0) ? (nl - 1 - k) : k;
            acc  = acc | ((32'(pval(seed, ln, i)) & ((32'd1 << w) - 32'd1)) << (lane * lw));
            if (k == nl - 1) begin
                exp_q.push_back(acc);
                acc = '0;
            end
        end
        if ((np % nl) != 0) exp_q.push_back(acc);
    endtask

    task automatic configure(input int mode, input int sw, input int hp, input int vp,
                             input int cp, input int al, input int tr);
        @(negedge clk);
        enable      = 1'b0;
        width_mode  = 3'(mode);
        swap        = 1'(sw);
        hs_pol      = 1'(hp);
        vs_pol      = 1'(vp);
        clk_pol     = 1'(cp);
        start_align = 1'(al);
        frame_trig  = 1'(tr);
        pclk        = 1'(cp);
        hsync       = 1'(hp);
        vsync       = 1'(vp);
        core_rst    = 1'b1;
        @(negedge clk);
        core_rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic begin_scn();
        exp_q.delete();
        q0  = got_q.size();
        fs0 = fs_n; fe0 = fe_n; ls0 = ls_n; le0 = le_n;
        efs = 0; efe = 0; els = 0; ele = 0;
    endtask

    task automatic end_scn(input string req);
        int n;
        repeat (6) @(negedge clk);
        n = got_q.size() - q0;
        check(req, "word count", 32'(n), 32'(exp_q.size()));
        for (int i = 0; i < n && i < exp_q.size(); i++)
            check(req, $sformatf("word %0d", i), got_q[q0 + i], exp_q[i]);
        check("R9", {req, " frame_start count"}, 32'(fs_n - fs0), 32'(efs));
        check("R9", {req, " frame_end count"},   32'(fe_n - fe0), 32'(efe));
        check("R9", {req, " line_start count"},  32'(ls_n - ls0), 32'(els));
        check("R9", {req, " line_end count"},    32'(le_n - le0), 32'(ele));
    endtask

    task automatic std_frame(input int mode, input int sw, input int nl,
                             input int np, input int seed);
        frame_open();
        for (int l = 0; l < nl; l++) begin
            send_line(np, seed, l);
            exp_line(mode, sw, np, seed, l);
        end
        frame_close();
        efs = 1; efe = 1; els = nl; ele = nl;
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        check("R1", "fifo_wr in reset", 32'(fifo_wr), 32'd0);
        check("R1", "fifo_data in reset", fifo_data, 32'd0);
        check("R1", "events in reset",
              32'({frame_start, frame_end, line_start, line_end}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 R5 R6 R7: sweep widths, swap and line lengths
        for (int mode = 0; mode < 3; mode++) begin
            for (int sw = 0; sw < 2; sw++) begin
                for (int np = 4; np < 8; np++) begin
                    string tag;
                    int nlane;
                    nlane = (mode == 0) ? 4 : 2;
                    tag = (mode == 0) ? "R4" : "R5";
                    if (sw != 0) tag = {tag, " R6"};
                    if ((np % nlane) != 0) tag = {tag, " R7"};
                    configure(mode, sw, 0, 0, 0, 1, 1);
                    enable = 1'b1;
                    begin_scn();
                    std_frame(mode, sw, 2, np, mode * 8 + sw * 4 + np);
                    end_scn(tag);
                end
            end
        end

        // R2 R3: every polarity combination
        for (int hp = 0; hp < 2; hp++) begin
            for (int vp = 0; vp < 2; vp++) begin
                for (int cp = 0; cp < 2; cp++) begin
                    configure(0, 0, hp, vp, cp, 1, 1);
                    enable = 1'b1;
                    begin_scn();
                    std_frame(0, 0, 2, 6, 50 + hp * 4 + vp * 2 + cp);
                    end_scn(cp != 0 ? "R2 R3" : "R3");
                end
            end
        end

        // R10: level start joins a frame already in progress
        configure(0, 0, 0, 0, 0, 0, 1);
        begin_scn();
        pc(1'b0, 1'b1, '0);
        pc(1'b0, 1'b1, '0);
        enable = 1'b1;
        pc(1'b0, 1'b1, '0);
        pc(1'b0, 1'b1, '0);
        send_line(4, 70, 0);
        exp_line(0, 0, 4, 70, 0);
        frame_close();
        efs = 1; efe = 1; els = 1; ele = 1;
        end_scn("R10 level start");

        // R10: aligned start skips it, then takes the next full frame
        configure(0, 0, 0, 0, 0, 1, 1);
        begin_scn();
        pc(1'b0, 1'b1, '0);
        pc(1'b0, 1'b1, '0);
        enable = 1'b1;
        pc(1'b0, 1'b1, '0);
        pc(1'b0, 1'b1, '0);
        send_line(4, 71, 0);
        frame_close();
        end_scn("R10 aligned skip");
        begin_scn();
        std_frame(0, 0, 1, 4, 72);
        end_scn("R10 aligned next frame");

        // R11: frame-bounded stop completes the frame
        configure(0, 0, 0, 0, 0, 1, 1);
        enable = 1'b1;
        begin_scn();
        frame_open();
        send_line(5, 80, 0);
        enable = 1'b0;
        send_line(5, 80, 1);
        send_line(5, 80, 2);
        frame_close();
        for (int l = 0; l < 3; l++) exp_line(0, 0, 5, 80, l);
        efs = 1; efe = 1; els = 3; ele = 3;
        end_scn("R11 frame-bounded stop");
        begin_scn();
        std_frame(0, 0, 2, 4, 81);
        exp_q.delete();
        efs = 0; efe = 0; els = 0; ele = 0;
        end_scn("R11 no later frame");

        // R11: immediate stop
        configure(1, 0, 0, 0, 0, 1, 0);
        enable = 1'b1;
        begin_scn();
        frame_open();
        send_line(3, 82, 0);
        enable = 1'b0;
        send_line(3, 82, 1);
        frame_close();
        exp_line(1, 0, 3, 82, 0);
        efs = 1; efe = 0; els = 1; ele = 1;
        end_scn("R11 immediate stop");

        // R12: ignored while enabled
        configure(0, 0, 0, 0, 0, 1, 1);
        enable = 1'b1;
        begin_scn();
        frame_open();
        send_line(4, 90, 0);
        core_rst = 1'b1;
        @(negedge clk);
        core_rst = 1'b0;
        send_line(4, 90, 1);
        send_line(4, 90, 2);
        frame_close();
        for (int l = 0; l < 3; l++) exp_line(0, 0, 4, 90, l);
        efs = 1; efe = 1; els = 3; ele = 3;
        end_scn("R12 ignored while enabled");

        // R12: accepted while disabled, ends the draining frame
        configure(0, 0, 0, 0, 0, 1, 1);
        enable = 1'b1;
        begin_scn();
        frame_open();
        send_line(4, 91, 0);
        enable = 1'b0;
        core_rst = 1'b1;
        @(negedge clk);
        core_rst = 1'b0;
        send_line(4, 91, 1);
        frame_close();
        exp_line(0, 0, 4, 91, 0);
        efs = 1; efe = 0; els = 1; ele = 1;
        end_scn("R12 accepted while disabled");

        // R8: unsupported width codes
        for (int c = 3; c < 8; c += 2) begin
            configure(c, 0, 0, 0, 0, 1, 1);
            enable = 1'b1;
            begin_scn();
            frame_open();
            send_line(4, 95, 0);
            frame_close();
            efs = 1; efe = 1; els = 1; ele = 1;
            end_scn("R8 unsupported mode");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule